// File: doc/BRIEF.md
# Codec Access Semaphore and PCM Data Port

This block is a small register bank that sits between a 32-bit register bus and the control logic of an audio-codec link. It provides two registers. The first is a hardware test-and-set semaphore. It lets several software drivers take turns at codec I/O cycles of any kind, including cycles that drive the codec's general-purpose pins. A driver reads the semaphore register. A returned 0 means the read itself has just claimed the semaphore, and the driver may start its cycle. A returned 1 means another driver owns the link, and the caller must retry later.

The semaphore is released in one of two ways. The link engine pulses `cyc_done` when the codec cycle finishes. A driver that claimed the semaphore but then chose not to run a cycle can release it by writing 0. If a release and a claiming read fall in the same clock, the release is applied first. The read then claims the now-free semaphore.

The second register is a PCM sample port. A write pushes one 32-bit stereo sample toward the transmit FIFO. A read pops one sample from the receive FIFO. A write into a full FIFO and a read from an empty FIFO both set a sticky error flag.

Top module: `codec_sem_regs`

## Requirements
- R1: The semaphore register is at byte offset 0x20 and the PCM register at byte offset 0x40. A read of any other offset returns 0. An access to any other offset changes no semaphore state, pops nothing and pushes nothing.
- R2: After reset, the semaphore is free, `err_flag` is 0, `bus_rdata` is 0, and both `tx_push` and `rx_pop` are low.
- R3: Read data appears on `bus_rdata` in the clock after the cycle in which `bus_rd` is high, and is 0 in every other clock. Semaphore reads return the state in bit 0, with bits 31:1 at 0.
- R4: A semaphore read that finds the semaphore free returns 0 and leaves the semaphore held.
- R5: A semaphore read that finds the semaphore held, with no release in the same clock, returns 1 and leaves it held.
- R6: A `cyc_done` pulse frees the semaphore, unless a semaphore read in the same clock claims it again.
- R7: Writing a word with bit 0 = 0 to the semaphore register frees it. Writing a word with bit 0 = 1 has no effect.
- R8: When `cyc_done` and a semaphore read occur in the same clock while the semaphore is held, the read returns 0 and the semaphore ends held.
- R9: A PCM write while `tx_full` is low asserts `tx_push` in that same clock, with `tx_data` equal to the written word. Bits 31:16 carry the right channel and bits 15:0 the left channel, both passed unchanged.
- R10: A PCM read while `rx_empty` is low asserts `rx_pop` in that same clock. The `rx_data` word presented in that clock is returned on `bus_rdata` in the next clock.
- R11: A PCM write while `tx_full` is high does not push. A PCM read while `rx_empty` is high does not pop and returns 0. Either event sets `err_flag`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one clock after the strobe |
| cyc_done | input | 1 | Pulse from the link engine when a codec cycle finishes |
| tx_push | output | 1 | Push request toward the transmit FIFO |
| tx_data | output | 32 | Sample word for the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO is full |
| rx_pop | output | 1 | Pop request toward the receive FIFO |
| rx_data | input | 32 | Head word of the receive FIFO (show-ahead) |
| rx_empty | input | 1 | Receive FIFO is empty |
| err_flag | output | 1 | Sticky overflow/underflow flag |

## Verification
The bound checker watches the following on every clock:
- every claim, busy read, hardware release and software release of the semaphore;
- the priority of a release over a claim in the same clock;
- that pushes and pops happen only when the FIFO allows them;
- the stickiness of the error flag;
- the zero upper bits and the zero data on unmapped reads.

Some behaviours only the bench scenarios can show. They sweep every combination of semaphore state, release pulse and bus operation. They visit every unmapped word offset and then confirm through the semaphore register that no state moved. They also show that stereo sample words pass through unchanged, and that the error flag clears only at reset.

// File: rtl/codec_sem_pkg.sv
package codec_sem_pkg;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic busy;
    } sem_state_t;

    typedef struct packed {
        logic err;
    } pcm_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_state_t;
endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] SEM_OFF = 8'h20,
    parameter logic [ADDR_W-1:0] PCM_OFF = 8'h40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              sem_rd,
    output logic              sem_wr,
    output logic              pcm_rd,
    output logic              pcm_wr
);
    logic hit_sem;
    logic hit_pcm;

    always_comb begin
        hit_sem = (addr == SEM_OFF);
        hit_pcm = (addr == PCM_OFF);
        sem_rd  = rd & hit_sem;
        sem_wr  = wr & hit_sem;
        pcm_rd  = rd & hit_pcm;
        pcm_wr  = wr & hit_pcm;
    end
endmodule

// File: rtl/sem_unit.sv
module sem_unit
    import codec_sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim_rd,
    input  logic sw_wr,
    input  logic sw_bit,
    input  logic hw_done,
    output logic rd_bit,
    output logic busy
);
    sem_state_t st_q, st_d;
    logic       after_release;

    // Release (hardware or software) is resolved before the claiming read.
    always_comb begin
        st_d          = st_q;
        after_release = st_q.busy & ~(hw_done | (sw_wr & ~sw_bit));
        rd_bit        = after_release;
        st_d.busy     = claim_rd ? 1'b1 : after_release;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/pcm_port.sv
module pcm_port
    import codec_sem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic [DATA_W-1:0] rx_data,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    output logic              rx_pop,
    output logic [DATA_W-1:0] rd_word,
    output logic              err
);
    pcm_state_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        tx_push = wr_req & ~tx_full;
        tx_data = wdata;
        rx_pop  = rd_req & ~rx_empty;
        rd_word = rx_pop ? rx_data : '0;
        if ((wr_req & tx_full) | (rd_req & rx_empty)) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err = st_q.err;
endmodule

// File: rtl/codec_sem_regs.sv
module codec_sem_regs
    import codec_sem_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] SEM_OFF = 8'h20,
    parameter logic [ADDR_W-1:0] PCM_OFF = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cyc_done,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_full,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_empty,
    output logic              err_flag
);
    logic              sem_rd, sem_wr, pcm_rd, pcm_wr;
    logic              sem_bit, sem_busy;
    logic [DATA_W-1:0] pcm_word;
    bus_state_t        bus_q, bus_d;

    csr_decode #(
        .ADDR_W (ADDR_W),
        .SEM_OFF(SEM_OFF),
        .PCM_OFF(PCM_OFF)
    ) u_dec (
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .sem_rd(sem_rd),
        .sem_wr(sem_wr),
        .pcm_rd(pcm_rd),
        .pcm_wr(pcm_wr)
    );

    sem_unit u_sem (
        .clk     (clk),
        .rst_n   (rst_n),
        .claim_rd(sem_rd),
        .sw_wr   (sem_wr),
        .sw_bit  (bus_wdata[0]),
        .hw_done (cyc_done),
        .rd_bit  (sem_bit),
        .busy    (sem_busy)
    );

    pcm_port u_pcm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (pcm_wr),
        .rd_req  (pcm_rd),
        .wdata   (bus_wdata),
        .tx_full (tx_full),
        .rx_empty(rx_empty),
        .rx_data (rx_data),
        .tx_push (tx_push),
        .tx_data (tx_data),
        .rx_pop  (rx_pop),
        .rd_word (pcm_word),
        .err     (err_flag)
    );

    always_comb begin
        bus_d = '0;
        if (sem_rd)      bus_d.rdata = {{(DATA_W-1){1'b0}}, sem_bit};
        else if (pcm_rd) bus_d.rdata = pcm_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign bus_rdata = bus_q.rdata;
endmodule

// File: rtl/codec_sem_chk.sv
module codec_sem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        cyc_done,
    input logic        sem_rd,
    input logic        sem_wr,
    input logic        wbit0,
    input logic        pcm_rd,
    input logic        pcm_wr,
    input logic        tx_full,
    input logic        rx_empty,
    input logic        tx_push,
    input logic        rx_pop,
    input logic        busy,
    input logic        err,
    input logic [31:0] bus_rdata
);
    a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !sem_rd && !pcm_rd) |=> (bus_rdata == 32'd0));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pcm_rd) |-> (bus_rdata[31:1] == 31'd0));

    a_r4_claim_free: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_rd && !busy) |=> (busy && bus_rdata == 32'd0));

    a_r5_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_rd && busy && !cyc_done && !(sem_wr && !wbit0)) |=> (busy && bus_rdata == 32'd1));

    a_r6_hw_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !sem_rd) |=> !busy);

    a_r7_sw_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_wr && !wbit0 && !sem_rd) |=> !busy);

    a_r8_release_then_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_rd && busy && cyc_done) |=> (busy && bus_rdata == 32'd0));

    a_r9_push_guard: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (pcm_wr && !tx_full));

    a_r10_pop_guard: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (pcm_rd && !rx_empty));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind codec_sem_regs codec_sem_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .cyc_done (cyc_done),
    .sem_rd   (sem_rd),
    .sem_wr   (sem_wr),
    .wbit0    (bus_wdata[0]),
    .pcm_rd   (pcm_rd),
    .pcm_wr   (pcm_wr),
    .tx_full  (tx_full),
    .rx_empty (rx_empty),
    .tx_push  (tx_push),
    .rx_pop   (rx_pop),
    .busy     (sem_busy),
    .err      (err_flag),
    .bus_rdata(bus_rdata)
);

// File: tb/tb_codec_sem_regs.sv
module tb_codec_sem_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        cyc_done;
    logic        tx_push, tx_full, rx_pop, rx_empty, err_flag;
    logic [31:0] tx_data, rx_data;

    int n_tests = 0;
    int n_fail  = 0;
    int pop_cnt = 0;

    localparam logic [7:0] SEM_A = 8'h20;
    localparam logic [7:0] PCM_A = 8'h40;

    always #10 clk = ~clk;

    codec_sem_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cyc_done(cyc_done), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .err_flag(err_flag)
    );

    always @(posedge clk) if (rx_pop) pop_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic rd, input logic wr, input logic [7:0] a,
                      input logic [31:0] wd, input logic done,
                      output logic [31:0] rdv, output logic push,
                      output logic [31:0] txd, output logic pop);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; cyc_done = done;
        #2;
        push = tx_push; txd = tx_data; pop = rx_pop;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; cyc_done = 1'b0;
        rdv = bus_rdata;
    endtask

    task automatic rd_sem(output logic [31:0] v);
        logic p, q; logic [31:0] t;
        op(1'b1, 1'b0, SEM_A, 32'h0, 1'b0, v, p, t, q);
    endtask

    task automatic wr_sem(input logic [31:0] wd);
        logic p, q; logic [31:0] t, v;
        op(1'b0, 1'b1, SEM_A, wd, 1'b0, v, p, t, q);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, txd;
        logic push, pop;
        rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
        cyc_done = 0; tx_full = 0; rx_empty = 1; rx_data = '0;
        repeat (3) @(negedge clk);
        // R2: reset values
        chk("R2 rdata", bus_rdata, 32'h0);
        chk("R2 err", {31'd0, err_flag}, 32'h0);
        chk("R2 push/pop", {30'd0, tx_push, rx_pop}, 32'h0);
        rst_n = 1'b1;
        rd_sem(v);
        chk("R2 sem free after reset", v, 32'h0);
        @(negedge clk);
        chk("R3 rdata zero without read", bus_rdata, 32'h0);
        wr_sem(32'h0);

        // Semaphore sweep: state x release pulse x operation
        for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int o = 0; o < 4; o++) begin
                    logic exp_fin;
                    string tag;
                    wr_sem(32'h0);
                    if (s == 1) rd_sem(v);
                    case (o)
                        0: op(1'b1, 1'b0, SEM_A, 32'h0, d[0], v, push, txd, pop);
                        1: op(1'b0, 1'b1, SEM_A, 32'hFFFF_FFFE, d[0], v, push, txd, pop);
                        2: op(1'b0, 1'b1, SEM_A, 32'h0000_0001, d[0], v, push, txd, pop);
                        default: op(1'b0, 1'b0, SEM_A, 32'h0, d[0], v, push, txd, pop);
                    endcase
                    if (o == 0) begin
                        tag = (d == 1) ? "R8" : ((s == 0) ? "R4" : "R5");
                        chk({tag, " read value"}, v, (d == 1) ? 32'h0 : 32'(s));
                        exp_fin = 1'b1;
                    end else if (o == 1) begin
                        tag = "R7"; exp_fin = 1'b0;
                    end else begin
                        tag = (d == 1) ? "R6" : "R7";
                        exp_fin = (d == 1) ? 1'b0 : s[0];
                    end
                    rd_sem(v);
                    chk({tag, " final state"}, v, {31'd0, exp_fin});
                end
            end
        end

        // R1: every unmapped word offset
        rx_empty = 1'b0; rx_data = 32'hA5A5_5A5A;
        for (int a = 0; a < 256; a += 4) begin
            int pc;
            if (a == 32'h20 || a == 32'h40) continue;
            wr_sem(32'h0);
            pc = pop_cnt;
            op(1'b1, 1'b0, 8'(a), 32'h0, 1'b0, v, push, txd, pop);
            chk("R1 unmapped read zero", v, 32'h0);
            chk("R1 unmapped no pop", 32'(pop_cnt - pc), 32'h0);
            rd_sem(v);
            chk("R1 unmapped read no claim", v, 32'h0);
            op(1'b0, 1'b1, 8'(a), 32'h0, 1'b0, v, push, txd, pop);
            chk("R1 unmapped write no push", {31'd0, push}, 32'h0);
            rd_sem(v);
            chk("R1 unmapped write no release", v, 32'h1);
        end
        rx_empty = 1'b1;
        wr_sem(32'h0);

        // PCM transmit
        do_reset();
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < 8; k++) begin
                logic [31:0] wd;
                wd = {16'(k * 4099 + 17), 16'(k * 257 + 3)};
                tx_full = f[0];
                op(1'b0, 1'b1, PCM_A, wd, 1'b0, v, push, txd, pop);
                if (f == 0) begin
                    chk("R9 push", {31'd0, push}, 32'h1);
                    chk("R9 right channel", {16'd0, txd[31:16]}, {16'd0, wd[31:16]});
                    chk("R9 left channel", {16'd0, txd[15:0]}, {16'd0, wd[15:0]});
                end else begin
                    chk("R11 full write dropped", {31'd0, push}, 32'h0);
                end
                chk("R11 err after write", {31'd0, err_flag}, 32'(f));
            end
        end
        tx_full = 1'b0;

        // PCM receive
        do_reset();
        chk("R2 err cleared by reset", {31'd0, err_flag}, 32'h0);
        for (int k = 0; k < 8; k++) begin
            rx_empty = 1'b0;
            rx_data = 32'h1234_0000 ^ 32'(k * 32'h0101_0301);
            op(1'b1, 1'b0, PCM_A, 32'h0, 1'b0, v, push, txd, pop);
            chk("R10 pop", {31'd0, pop}, 32'h1);
            chk("R10 data", v, 32'h1234_0000 ^ 32'(k * 32'h0101_0301));
            @(negedge clk);
            chk("R3 data lasts one clock", bus_rdata, 32'h0);
        end
        chk("R11 no err on good reads", {31'd0, err_flag}, 32'h0);
        rx_empty = 1'b1; rx_data = 32'hDEAD_BEEF;
        op(1'b1, 1'b0, PCM_A, 32'h0, 1'b0, v, push, txd, pop);
        chk("R11 empty read zero", v, 32'h0);
        chk("R11 empty no pop", {31'd0, pop}, 32'h0);
        chk("R11 err set", {31'd0, err_flag}, 32'h1);
        rx_empty = 1'b0;
        op(1'b1, 1'b0, PCM_A, 32'h0, 1'b0, v, push, txd, pop);
        op(1'b0, 1'b1, PCM_A, 32'h55AA_33CC, 1'b0, v, push, txd, pop);
        chk("R11 err sticky", {31'd0, err_flag}, 32'h1);
        do_reset();
        chk("R2 err clear after reset", {31'd0, err_flag}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule